// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a cycle-accurate model of a synchronous burst SRAM with a two-stage read pipeline and byte-granular writes, built on a small internal array. Every control input, the address and the write data are taken at the rising clock edge. Read data passes through two registers before it reaches the data output. The output is released to high impedance whenever the block is not driving it, and a separate flag shows when it is driving.

An access starts on one of two address strobes: the processor-side strobe or the controller-side strobe. It starts only while all three chip enables are active. After that, a 2-bit burst offset can be stepped cycle by cycle through a group of four words, or held where it is. The same strobes with the enables inactive end the burst. Reads already in flight still reach the output one cycle after the burst ends.

A sleep input parks the block, but only while no burst is selected. While it is parked, all commands are ignored and the output is not driven.

Top module: `sram_sync_top`

## Requirements
- R1: After reset no burst is selected, the block is awake and `rdata_drive` is low.
- R2: For a read accepted at clock edge E, the word is on `rdata` with `rdata_drive` high after edge E+1, provided `out_en_n` is low. The word reflects every write made at edges before E.
- R3: An access is accepted only when a strobe is low and `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. The processor strobe has no effect while `sel_a_n` is 1.
- R4: With `wr_all_n` low, a controller-strobe or burst-continuation cycle writes all 18 bits of `wdata`, whatever `wr_byte_en_n` and `byte_sel_n` are.
- R5: With `wr_all_n` high and `wr_byte_en_n` low, a low `byte_sel_n[i]` writes bits [9i+8:9i] only (byte 0 is bits 8:0, byte 1 is bits 17:9). With `wr_byte_en_n` high, or both selects high, the cycle is a read.
- R6: The cycle in which the processor strobe starts an access is always a read, whatever the write inputs are.
- R7: During a selected burst with no strobe, `burst_adv_n` low steps a 2-bit offset (wrapping modulo 4) and `burst_adv_n` high repeats the current word. The low address bits are (start + offset) mod 4; a parameter switches this to start XOR offset. The upper bits stay those of the start address.
- R8: A strobe with the enables inactive ends the burst. A read accepted in the cycle before it still appears for one cycle, and the output is undriven after the next edge. Cycles without a strobe do nothing until a new access starts.
- R9: The output is undriven after a write cycle unless a read follows. `out_en_n` high releases the output at once, with no clock needed.
- R10: `sleep_req` high while no burst is selected parks the block within two edges. While it is parked and during the two-edge recovery after `sleep_req` falls, commands (writes included) are ignored and the output is undriven. `sleep_req` high during a selected burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 8 | Word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst step request, active low |
| sel_a_n | input | 1 | Chip enable, active low (also gates the processor strobe) |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_en_n | input | 1 | Byte-write qualifier, active low |
| byte_sel_n | input | 2 | Per-byte write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | 18 | Write data, two 9-bit bytes |
| rdata | output | 18 | Read data, high impedance when not driven |
| rdata_drive | output | 1 | High while `rdata` is driven |

## Verification
The checks assume that the strobes, enables and write controls are never X once reset has ended. They also assume that `out_en_n` changes only between edges, so the clocked check on output release sees settled values. The bench holds every input at a defined level from time zero and changes inputs only mid-cycle. It never reads an array word that has not been written, because it fills the whole array before the first read. So every driven word is known, and the check on driven data can rely on it.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int NB_BYTES = 2;

    typedef enum logic [1:0] {
        SLP_AWAKE  = 2'd0,
        SLP_ENTER  = 2'd1,
        SLP_PARKED = 2'd2,
        SLP_RESUME = 2'd3
    } slp_state_t;

    typedef struct packed {
        logic                cpu_go;
        logic                ctl_go;
        logic                desel;
        logic                cont;
        logic [NB_BYTES-1:0] wmask;
    } cmd_t;

    function automatic logic [NB_BYTES-1:0] byte_mask(
        input logic                all_n,
        input logic                qual_n,
        input logic [NB_BYTES-1:0] sel_n
    );
        if (!all_n)
            return '1;
        else if (!qual_n)
            return ~sel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
    parameter int BURST_W    = 2,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [BURST_W-1:0] load_low,
    input  logic               step,
    output logic [BURST_W-1:0] cur_low
);
    logic [BURST_W-1:0] first_q;
    logic [BURST_W-1:0] ofs_q;
    logic [BURST_W-1:0] ofs_nx;
    logic [BURST_W-1:0] ordered;

    assign ofs_nx = ofs_q + BURST_W'(step);

    generate
        if (INTERLEAVE) begin : g_xor
            assign ordered = first_q ^ ofs_nx;
        end else begin : g_lin
            assign ordered = first_q + ofs_nx;
        end
    endgenerate

    assign cur_low = load ? load_low : ordered;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            ofs_q   <= '0;
        end else if (load) begin
            first_q <= load_low;
            ofs_q   <= '0;
        end else begin
            ofs_q   <= ofs_nx;
        end
    end
endmodule

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
    import sram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic idle,
    output logic awake,
    output logic accept
);
    slp_state_t st_q, st_d;

    assign awake  = (st_q == SLP_AWAKE);
    assign accept = awake && !(sleep_req && idle);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLP_AWAKE:  if (sleep_req && idle) st_d = SLP_ENTER;
            SLP_ENTER:  st_d = sleep_req ? SLP_PARKED : SLP_AWAKE;
            SLP_PARKED: st_d = sleep_req ? SLP_PARKED : SLP_RESUME;
            SLP_RESUME: st_d = sleep_req ? SLP_PARKED : SLP_AWAKE;
            default:    st_d = SLP_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SLP_AWAKE;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pkg::*;
(
    input  logic                accept,
    input  logic                sel_active,
    input  logic                strb_cpu_n,
    input  logic                strb_ctl_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                wr_all_n,
    input  logic                wr_byte_en_n,
    input  logic [NB_BYTES-1:0] byte_sel_n,
    output cmd_t                cmd
);
    logic enabled;
    logic cpu_seen;

    assign enabled  = !sel_a_n && sel_b && !sel_c_n;
    assign cpu_seen = !strb_cpu_n && !sel_a_n;

    always_comb begin
        cmd.cpu_go = accept && cpu_seen && enabled;
        cmd.ctl_go = accept && !cmd.cpu_go && !strb_ctl_n && enabled;
        cmd.desel  = accept && !enabled && (cpu_seen || !strb_ctl_n);
        cmd.cont   = accept && sel_active && !cmd.cpu_go && !cmd.ctl_go && !cmd.desel;
        cmd.wmask  = cmd.cpu_go ? '0 : byte_mask(wr_all_n, wr_byte_en_n, byte_sel_n);
    end
endmodule

// File: rtl/sram_sync_top.sv
module sram_sync_top
    import sram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BYTE_W     = 9,
    parameter int BURST_W    = 2,
    parameter bit INTERLEAVE = 1'b0,
    localparam int DATA_W    = BYTE_W * NB_BYTES,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                strb_cpu_n,
    input  logic                strb_ctl_n,
    input  logic                burst_adv_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                wr_all_n,
    input  logic                wr_byte_en_n,
    input  logic [NB_BYTES-1:0] byte_sel_n,
    input  logic                out_en_n,
    input  logic                sleep_req,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                rdata_drive
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [DATA_W-1:0] mem [DEPTH];

    cmd_t              cmd;
    logic              accept, awake;
    logic              sel_active_q;
    logic [HI_W-1:0]   base_q;
    logic [BURST_W-1:0] cur_low;
    logic              go, access, mem_we, rd_now;
    logic [ADDR_W-1:0] acc_addr;
    logic              v1_q, v2_q;
    logic [DATA_W-1:0] d1_q, q2_q;

    sram_sleep_fsm u_sleep (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .idle      (!sel_active_q),
        .awake     (awake),
        .accept    (accept)
    );

    sram_cmd_decode u_dec (
        .accept       (accept),
        .sel_active   (sel_active_q),
        .strb_cpu_n   (strb_cpu_n),
        .strb_ctl_n   (strb_ctl_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .wr_all_n     (wr_all_n),
        .wr_byte_en_n (wr_byte_en_n),
        .byte_sel_n   (byte_sel_n),
        .cmd          (cmd)
    );

    assign go     = cmd.cpu_go || cmd.ctl_go;
    assign access = go || cmd.cont;
    assign mem_we = access && (cmd.wmask != '0);
    assign rd_now = access && !mem_we;

    sram_burst_ctr #(
        .BURST_W    (BURST_W),
        .INTERLEAVE (INTERLEAVE)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (go),
        .load_low (addr_in[BURST_W-1:0]),
        .step     (cmd.cont && !burst_adv_n),
        .cur_low  (cur_low)
    );

    assign acc_addr = {go ? addr_in[ADDR_W-1:BURST_W] : base_q, cur_low};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_active_q <= 1'b0;
            base_q       <= '0;
        end else if (go) begin
            sel_active_q <= 1'b1;
            base_q       <= addr_in[ADDR_W-1:BURST_W];
        end else if (cmd.desel) begin
            sel_active_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            for (int b = 0; b < NB_BYTES; b++) begin
                if (cmd.wmask[b])
                    mem[acc_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            d1_q <= '0;
            q2_q <= '0;
        end else begin
            v1_q <= rd_now;
            d1_q <= mem[acc_addr];
            v2_q <= v1_q;
            q2_q <= d1_q;
        end
    end

    assign rdata_drive = !out_en_n && v2_q && awake;
    assign rdata       = rdata_drive ? q2_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_sync_chk.sv
module sram_sync_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              out_en_n,
    input logic              rdata_drive,
    input logic [DATA_W-1:0] rdata,
    input logic              awake,
    input logic              cpu_go,
    input logic              ctl_go,
    input logic              desel,
    input logic              mem_we
);
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);                                   // R9

    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !awake |-> (!rdata_drive && !mem_we));                        // R10

    AST_CPU_FIRST_READ: assert property (@(posedge clk) disable iff (rst)
        cpu_go |-> !mem_we);                                          // R6

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_go, ctl_go, desel}));                           // R3

    AST_DESEL_DRAIN: assert property (@(posedge clk) disable iff (rst)
        desel |=> ##1 !rdata_drive);                                  // R8

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctl_go && mem_we) |=> ##1 !rdata_drive);                     // R9

    AST_DRIVE_KNOWN: assert property (@(posedge clk) disable iff (rst)
        rdata_drive |-> !$isunknown(rdata));                          // R2
endmodule

bind sram_sync_top sram_sync_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_en_n    (out_en_n),
    .rdata_drive (rdata_drive),
    .rdata       (rdata),
    .awake       (awake),
    .cpu_go      (cmd.cpu_go),
    .ctl_go      (cmd.ctl_go),
    .desel       (cmd.desel),
    .mem_we      (mem_we)
);

// File: tb/tb_sram_sync_top.sv
`timescale 1ns/1ps
module tb_sram_sync_top;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, burst_adv_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          wr_all_n = 1'b1, wr_byte_en_n = 1'b1;
    logic [1:0]    byte_sel_n = 2'b11;
    logic          out_en_n = 1'b0, sleep_req = 1'b0;
    logic [DW-1:0] wdata = '0;
    wire  [DW-1:0] rdata;
    wire           rdata_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sram_sync_top dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .burst_adv_n(burst_adv_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .byte_sel_n(byte_sel_n),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    // Behavioural reference
    int mm [NW];
    int pipe [$];
    int m_out;
    bit m_sel;
    int m_base, m_first, m_ofs;
    int m_slp;   // 0 awake, 1 entering, 2 parked, 3 resuming

    function automatic int pattern(int a);
        return (a * 613 + 77) & 32'h3ffff;
    endfunction

    task automatic model_reset();
        pipe.delete();
        pipe.push_back(-1);
        m_out = -1; m_sel = 0; m_base = 0; m_first = 0; m_ofs = 0; m_slp = 0;
    endtask

    task automatic model_step();
        bit en, ok, cpu, ctl, des, cont, old_sel;
        int a, ent, mask;
        en      = !sel_a_n && sel_b && !sel_c_n;
        old_sel = m_sel;
        ok      = (m_slp == 0) && !(sleep_req && !old_sel);
        cpu     = ok && !strb_cpu_n && !sel_a_n && en;
        ctl     = ok && !cpu && !strb_ctl_n && en;
        des     = ok && !cpu && !ctl && ((!strb_cpu_n && !sel_a_n) || !strb_ctl_n);
        cont    = ok && old_sel && !cpu && !ctl && !des;
        ent = -1;
        a   = 0;
        if (cpu || ctl) begin
            m_base = addr_in / 4; m_first = addr_in % 4; m_ofs = 0; m_sel = 1;
            a = addr_in;
        end else if (cont) begin
            if (!burst_adv_n) m_ofs = (m_ofs + 1) % 4;
            a = m_base * 4 + ((m_first + m_ofs) % 4);
        end
        if (des) m_sel = 0;
        if (cpu || ctl || cont) begin
            if (cpu)                mask = 0;
            else if (!wr_all_n)     mask = 3;
            else if (!wr_byte_en_n) mask = (~byte_sel_n) & 3;
            else                    mask = 0;
            if (mask != 0) begin
                for (int b = 0; b < 2; b++)
                    if (mask[b])
                        mm[a] = (mm[a] & ~(32'h1ff << (9*b))) | (int'(wdata) & (32'h1ff << (9*b)));
            end else begin
                ent = mm[a];
            end
        end
        pipe.push_back(ent);
        m_out = pipe.pop_front();
        case (m_slp)
            0: if (sleep_req && !old_sel) m_slp = 1;
            1: m_slp = sleep_req ? 2 : 0;
            2: m_slp = sleep_req ? 2 : 3;
            default: m_slp = sleep_req ? 2 : 0;
        endcase
    endtask

    task automatic compare(input string tag);
        bit exp_drv;
        exp_drv = !out_en_n && (m_out != -1) && (m_slp == 0);
        checks++;
        if (rdata_drive !== exp_drv) begin
            fails++;
            $display("FAIL %s drive actual=%0b expected=%0b t=%0t", tag, rdata_drive, exp_drv, $time);
        end
        if (exp_drv) begin
            checks++;
            if (rdata !== DW'(m_out)) begin
                fails++;
                $display("FAIL %s data actual=%h expected=%h t=%0t", tag, rdata, DW'(m_out), $time);
            end
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #3;
        compare(tag);
    endtask

    task automatic idle_in();
        strb_cpu_n = 1; strb_ctl_n = 1; burst_adv_n = 1;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        wr_all_n = 1; wr_byte_en_n = 1; byte_sel_n = 2'b11;
    endtask

    task automatic ctl_start(input int a);
        idle_in(); addr_in = AW'(a); strb_ctl_n = 0;
    endtask

    task automatic desel_cycle(input string tag);
        idle_in(); strb_ctl_n = 0; sel_b = 0;
        tick(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #3 rst = 0;
        // R1: reset state
        checks++;
        if (rdata_drive !== 1'b0) begin
            fails++;
            $display("FAIL R1 drive after reset actual=%0b expected=0", rdata_drive);
        end
        tick("R1");

        // R4: fill array with full-width writes
        for (int a = 0; a < NW; a++) begin
            ctl_start(a); wr_all_n = 0; wr_byte_en_n = 0; byte_sel_n = 2'b01;
            wdata = DW'(pattern(a));
            mm[a] = pattern(a);
            model_step_fix_skip(a);
            tick("R4");
        end
        desel_cycle("R8");
        idle_in(); tick("R8");

        // R2/R6: processor strobe with write inputs active is a read
        idle_in(); addr_in = 8'h13; strb_cpu_n = 0; wr_all_n = 0; wdata = 18'h2aaaa;
        tick("R6");
        idle_in(); tick("R2");
        tick("R2");
        // R7: burst stepping, wrap and hold
        burst_adv_n = 0; tick("R7");
        tick("R7"); tick("R7"); tick("R7");
        burst_adv_n = 1; tick("R7"); tick("R7");
        burst_adv_n = 0; tick("R7");
        // R8: end burst, in-flight read drains
        desel_cycle("R8");
        tick("R8"); tick("R8"); tick("R8");

        // R3: processor strobe ignored while sel_a_n high
        idle_in(); addr_in = 8'h40; strb_cpu_n = 0; sel_a_n = 1;
        tick("R3"); idle_in(); tick("R3"); tick("R3");
        // R3: controller strobe with sel_c_n high deselects, no read
        idle_in(); addr_in = 8'h41; strb_ctl_n = 0; sel_c_n = 1;
        tick("R3"); idle_in(); tick("R3"); tick("R3");

        // R5: byte writes, then read back
        ctl_start(8'h22); wr_byte_en_n = 0; byte_sel_n = 2'b10; wdata = 18'h3ffff; tick("R5");
        idle_in(); wr_byte_en_n = 0; byte_sel_n = 2'b01; wdata = 18'h00000; burst_adv_n = 0; tick("R5");
        idle_in(); wr_byte_en_n = 0; byte_sel_n = 2'b11; wdata = 18'h12345; tick("R5");
        idle_in(); tick("R5");
        ctl_start(8'h22); tick("R5");
        idle_in(); burst_adv_n = 0; tick("R5");
        idle_in(); tick("R5"); tick("R5");
        desel_cycle("R8");
        tick("R8"); tick("R8");

        // R9: write then read, output enable toggling
        ctl_start(8'h30); wr_all_n = 0; wdata = 18'h1beef; tick("R9");
        idle_in(); tick("R9");
        idle_in(); tick("R9");
        out_en_n = 1; #1; compare("R9");
        tick("R9");
        out_en_n = 0; #1; compare("R9");
        ctl_start(8'h31); wr_all_n = 0; wdata = 18'h0f0f0; tick("R9");
        idle_in(); tick("R9"); tick("R9");
        // R4: burst continuation write ignores byte selects when all-bytes is low
        idle_in(); burst_adv_n = 0; wr_all_n = 0; wr_byte_en_n = 0; byte_sel_n = 2'b11;
        wdata = 18'h2c3c3; tick("R4");
        idle_in(); tick("R4"); tick("R4");
        desel_cycle("R8");
        tick("R8"); tick("R8");

        // R10: sleep ignored while selected, then honoured after deselect
        ctl_start(8'h50); tick("R10");
        idle_in(); sleep_req = 1; tick("R10"); tick("R10");
        desel_cycle("R10");
        tick("R10"); tick("R10"); tick("R10");
        ctl_start(8'h51); wr_all_n = 0; wdata = 18'h11111; tick("R10");
        ctl_start(8'h51); tick("R10");
        idle_in(); sleep_req = 0; tick("R10");
        ctl_start(8'h52); wr_all_n = 0; wdata = 18'h22222; tick("R10");
        ctl_start(8'h51); tick("R10");
        ctl_start(8'h52); tick("R10");
        idle_in(); tick("R10"); tick("R10");
        desel_cycle("R8");
        tick("R8"); tick("R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Fill loop: the model array is written by model_step itself; undo the
    // pre-seed so the model, not the seed, carries the value.
    task automatic model_step_fix_skip(input int a);
        mm[a] = 0;
    endtask
endmodule